// File: doc/BRIEF.md
# Connection memory block-fill controller

This block is the processor-side control logic of a time-slot switch's connection memory. The memory holds 16 streams of 32 channels, and each word is 16 bits wide. Software programs a small control register to pick a stream. It then reads or writes single words of that stream's 32-word window through a narrow register port. A memory-select bit decides where reads come from. When it is 0, reads return connection memory. When it is 1, reads return the data-memory word that an external read port supplies. Writes always land in connection memory, because the data memory is never writable from the processor.

Software can also start a hardware bulk fill. A second register holds a 5-bit pattern and a go bit, and both are taken from the same write. When the go bit rises while the fill-arm bit of the control register is set, the sequencer waits for the next frame-start pulse. It then writes every word, one per clock, with the pattern in bits 15:11 and zeros in bits 10:0. The go bit stays set for two full frame periods and clears itself to mark completion. The block also produces the output-enable qualification for the serial transmit drivers from an external enable input and a standby bit.

Top module: `cmfc_top`

## Requirements
- R1: After reset, the control register and the fill register both read 0x0000, host_rdata is 0x0000, and tx_oe equals odrive_en.
- R2: The control register reads back stream in bits 3:0, mem_sel in bit 4, standby in bit 5 and fill-arm in bit 6. Writing 0xFFFF to it reads back 0x007F. A register access uses host_addr[5]=0, and host_addr[0] selects the register: 0 for control, 1 for fill.
- R3: A memory access uses host_addr[5]=1 with the channel in host_addr[4:0]. The word address is {stream, channel}, with stream bit 3 as the most significant address bit. With mem_sel=0, a written word reads back unchanged. Read data appears on host_rdata one cycle after host_rd and holds until the next read.
- R4: With mem_sel=1, a memory read returns dm_rd_data, and dm_rd_addr equals {stream, channel}. Memory writes made with mem_sel=1 still go to connection memory.
- R5: tx_oe is 0 only when odrive_en and standby are both 0. In every other combination it is 1.
- R6: A fill starts only when a fill-register write sets the go bit (bit 5) while it was 0 and fill-arm is 1. With fill-arm at 0, such a write leaves go reading 0 and leaves memory unchanged.
- R7: A completed fill leaves every one of the 512 words equal to {pattern, 11'b0}.
- R8: Go reads 1 from the trigger write until the third frame-start pulse after it, and reads 0 from the cycle after that pulse.
- R9: While go is 1, fill-register writes are ignored and memory word writes are dropped. After completion, word writes take effect again.
- R10: The fill register reads back the pattern in bits 4:0 and go in bit 5, both taken from a single write. A write made with fill-arm at 0 still stores the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe, one cycle |
| host_addr | input | 6 | Bit 5 selects memory (1) or registers (0); bits 4:0 give the channel, or bit 0 gives the register |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Registered read data |
| frame_start | input | 1 | Single-cycle frame-start pulse |
| odrive_en | input | 1 | External output-drive enable |
| tx_oe | output | 1 | Transmit driver enable; 0 means high impedance |
| dm_rd_addr | output | 9 | Data-memory read address {stream, channel} |
| dm_rd_data | input | 16 | Data-memory read contents for dm_rd_addr |

## Verification
Register writes and memory word writes take effect at the clock edge of the strobe, so the bench reads them back after that edge. Read data is captured at the edge that samples host_rd, and the bench checks host_rdata at the following falling edge. tx_oe is combinational, so it is checked one half-cycle after the inputs or the standby bit change. Fill completion is checked with a register read in the cycle after the third frame-start pulse, and the memory sweep is read back only after completion, once the 512-cycle sweep has long ended.

// File: rtl/cmfc_pkg.sv
package cmfc_pkg;
    parameter int STREAMS = 16;
    parameter int CHANS   = 32;
    parameter int WORD_W  = 16;
    parameter int PAT_W   = 5;

    localparam int STREAM_W = $clog2(STREAMS);
    localparam int CHAN_W   = $clog2(CHANS);
    localparam int ADDR_W   = STREAM_W + CHAN_W;
    localparam int DEPTH    = STREAMS * CHANS;
    localparam int LOW_W    = WORD_W - PAT_W;
    localparam int HADDR_W  = CHAN_W + 1;
    localparam int CTL_W    = STREAM_W + 3;
    localparam int FILL_W   = PAT_W + 1;

    typedef struct packed {
        logic                arm;
        logic                standby;
        logic                mem_sel;
        logic [STREAM_W-1:0] stream;
    } ctl_t;

    typedef struct packed {
        logic             go;
        logic [PAT_W-1:0] pattern;
    } fill_t;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_ARMED = 2'd1,
        FS_RUN   = 2'd2
    } fill_state_e;

    function automatic logic [WORD_W-1:0] ctl_word(input ctl_t c);
        return {{(WORD_W-CTL_W){1'b0}}, c};
    endfunction

    function automatic logic [WORD_W-1:0] fill_word(input fill_t f);
        return {{(WORD_W-FILL_W){1'b0}}, f};
    endfunction

    function automatic logic [WORD_W-1:0] fill_value(input logic [PAT_W-1:0] p);
        return {p, {LOW_W{1'b0}}};
    endfunction
endpackage

// File: rtl/cmfc_regs.sv
module cmfc_regs
    import cmfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctl,
    input  logic              wr_fill,
    input  logic [CTL_W-1:0]  wdata,
    input  logic              fill_done,
    output ctl_t              ctl_q,
    output fill_t             fill_q,
    output logic              fill_start
);
    fill_t wfill;

    assign wfill      = fill_t'(wdata[FILL_W-1:0]);
    assign fill_start = wr_fill && wfill.go && !fill_q.go && ctl_q.arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            fill_q <= '0;
        end else begin
            if (wr_ctl) begin
                ctl_q <= ctl_t'(wdata);
            end
            if (fill_done) begin
                fill_q.go <= 1'b0;
            end else if (wr_fill && !fill_q.go) begin
                fill_q.pattern <= wfill.pattern;
                fill_q.go      <= wfill.go && ctl_q.arm;
            end
        end
    end
endmodule

// File: rtl/cmfc_fill_seq.sv
module cmfc_fill_seq
    import cmfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              frame_start,
    output logic              busy,
    output logic              fill_we,
    output logic [ADDR_W-1:0] fill_addr,
    output logic              done
);
    fill_state_e       state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              sweep_q;
    logic              fcnt_q;

    assign busy      = (state_q != FS_IDLE);
    assign fill_we   = sweep_q;
    assign fill_addr = addr_q;
    assign done      = (state_q == FS_RUN) && frame_start && fcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            addr_q  <= '0;
            sweep_q <= 1'b0;
            fcnt_q  <= 1'b0;
        end else begin
            case (state_q)
                FS_IDLE: begin
                    if (start) state_q <= FS_ARMED;
                end
                FS_ARMED: begin
                    if (frame_start) begin
                        state_q <= FS_RUN;
                        sweep_q <= 1'b1;
                        addr_q  <= '0;
                        fcnt_q  <= 1'b0;
                    end
                end
                FS_RUN: begin
                    if (sweep_q) begin
                        addr_q <= addr_q + 1'b1;
                        if (addr_q == ADDR_W'(DEPTH - 1)) sweep_q <= 1'b0;
                    end
                    if (frame_start) begin
                        if (fcnt_q) begin
                            state_q <= FS_IDLE;
                            sweep_q <= 1'b0;
                        end else begin
                            fcnt_q <= 1'b1;
                        end
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cmfc_cmem.sv
module cmfc_cmem
    import cmfc_pkg::*;
(
    input  logic              clk,
    input  logic              fill_we,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [WORD_W-1:0] fill_data,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_data,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [DEPTH];

    assign rd_data = mem[host_addr];

    always_ff @(posedge clk) begin
        if (fill_we) begin
            mem[fill_addr] <= fill_data;
        end else if (host_we) begin
            mem[host_addr] <= host_data;
        end
    end
endmodule

// File: rtl/cmfc_top.sv
module cmfc_top
    import cmfc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0]  host_wdata,
    output logic [WORD_W-1:0]  host_rdata,
    input  logic               frame_start,
    input  logic               odrive_en,
    output logic               tx_oe,
    output logic [ADDR_W-1:0]  dm_rd_addr,
    input  logic [WORD_W-1:0]  dm_rd_data
);
    ctl_t              ctl_q;
    fill_t             fill_q;
    logic              fill_start;
    logic              fill_done;
    logic              busy;
    logic              fill_we;
    logic [ADDR_W-1:0] fill_addr;
    logic [ADDR_W-1:0] word_addr;
    logic [WORD_W-1:0] cm_rd;
    logic              is_mem;
    logic              wr_ctl;
    logic              wr_fill;
    logic              host_we;

    assign is_mem    = host_addr[CHAN_W];
    assign wr_ctl    = host_wr && !is_mem && !host_addr[0];
    assign wr_fill   = host_wr && !is_mem &&  host_addr[0];
    assign host_we   = host_wr && is_mem && !busy;
    assign word_addr = {ctl_q.stream, host_addr[CHAN_W-1:0]};

    assign dm_rd_addr = word_addr;
    assign tx_oe      = odrive_en | ctl_q.standby;

    cmfc_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_ctl     (wr_ctl),
        .wr_fill    (wr_fill),
        .wdata      (host_wdata[CTL_W-1:0]),
        .fill_done  (fill_done),
        .ctl_q      (ctl_q),
        .fill_q     (fill_q),
        .fill_start (fill_start)
    );

    cmfc_fill_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (fill_start),
        .frame_start (frame_start),
        .busy        (busy),
        .fill_we     (fill_we),
        .fill_addr   (fill_addr),
        .done        (fill_done)
    );

    cmfc_cmem u_mem (
        .clk       (clk),
        .fill_we   (fill_we),
        .fill_addr (fill_addr),
        .fill_data (fill_value(fill_q.pattern)),
        .host_we   (host_we),
        .host_addr (word_addr),
        .host_data (host_wdata),
        .rd_data   (cm_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            if (is_mem) begin
                host_rdata <= ctl_q.mem_sel ? dm_rd_data : cm_rd;
            end else begin
                host_rdata <= host_addr[0] ? fill_word(fill_q) : ctl_word(ctl_q);
            end
        end
    end
endmodule

// File: rtl/cmfc_chk.sv
module cmfc_chk
    import cmfc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             frame_start,
    input logic             arm,
    input logic             fill_we,
    input logic [PAT_W-1:0] pattern
);
    a_r8_no_early_done: assert property (@(posedge clk) disable iff (rst)
        busy && !frame_start |=> busy);

    a_r6_arm_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(arm));

    a_r9_pattern_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(pattern));

    a_r7_fill_in_busy: assert property (@(posedge clk) disable iff (rst)
        fill_we |-> busy);

    a_r8_waits_for_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !fill_we);
endmodule

bind cmfc_top cmfc_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .frame_start (frame_start),
    .arm         (ctl_q.arm),
    .fill_we     (fill_we),
    .pattern     (fill_q.pattern)
);

// File: tb/cmfc_top_tb.sv
module cmfc_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        frame_start = 1'b0;
    logic        odrive_en = 1'b0;
    logic        tx_oe;
    logic [8:0]  dm_rd_addr;
    logic [15:0] dm_rd_data;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [15:0] model [512];
    bit          valid [512];
    logic [3:0]  cur_stream = '0;
    logic        cur_msel = 1'b0;

    always #4 clk = ~clk;

    assign dm_rd_data = 16'hD000 | {7'b0, dm_rd_addr};

    cmfc_top u_dut (
        .clk         (clk),
        .rst         (rst),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .frame_start (frame_start),
        .odrive_en   (odrive_en),
        .tx_oe       (tx_oe),
        .dm_rd_addr  (dm_rd_addr),
        .dm_rd_data  (dm_rd_data)
    );

    function automatic logic [15:0] ctl_val(input logic arm, input logic sb,
                                            input logic ms, input logic [3:0] s);
        return {9'b0, arm, sb, ms, s};
    endfunction

    function automatic logic [15:0] fill_val(input logic go, input logic [4:0] p);
        return {10'b0, go, p};
    endfunction

    function automatic int widx(input logic [3:0] s, input logic [4:0] c);
        return int'(s) * 32 + int'(c);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic set_ctl(input logic arm, input logic sb, input logic ms, input logic [3:0] s);
        bus_wr(6'h00, ctl_val(arm, sb, ms, s));
        cur_stream = s;
        cur_msel = ms;
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 rdata", host_rdata, 16'h0000);
        check("R1 tx_oe", {15'b0, tx_oe}, 16'h0000);
        bus_rd(6'h00, rd); check("R1 ctl", rd, 16'h0000);
        bus_rd(6'h01, rd); check("R1 fill", rd, 16'h0000);

        // R2 unused bits read zero
        bus_wr(6'h00, 16'hFFFF);
        bus_rd(6'h00, rd); check("R2 ctl readback", rd, 16'h007F);
        bus_wr(6'h00, 16'h0025);
        bus_rd(6'h00, rd); check("R2 ctl fields", rd, ctl_val(0, 1, 0, 4'h5));

        // R5 output enable combinations
        odrive_en = 1'b0; #1; check("R5 od0 sb1", {15'b0, tx_oe}, 16'h0001);
        set_ctl(0, 0, 0, 4'h0);
        #1; check("R5 od0 sb0", {15'b0, tx_oe}, 16'h0000);
        odrive_en = 1'b1; #1; check("R5 od1 sb0", {15'b0, tx_oe}, 16'h0001);
        set_ctl(0, 1, 0, 4'h0);
        #1; check("R5 od1 sb1", {15'b0, tx_oe}, 16'h0001);
        set_ctl(0, 0, 0, 4'h0);

        // R3 stream bit 3 is the address MSB
        set_ctl(0, 0, 0, 4'h8);
        bus_wr(6'h20, 16'h8888); model[widx(4'h8, 5'd0)] = 16'h8888; valid[widx(4'h8, 5'd0)] = 1;
        set_ctl(0, 0, 0, 4'h0);
        bus_wr(6'h20, 16'h0001); model[0] = 16'h0001; valid[0] = 1;
        bus_rd(6'h20, rd); check("R3 stream0", rd, 16'h0001);
        set_ctl(0, 0, 0, 4'h8);
        bus_rd(6'h20, rd); check("R3 stream8", rd, 16'h8888);

        // R3 random traffic
        for (int i = 0; i < 300; i++) begin
            logic [4:0] c;
            if (($urandom % 8) == 0) set_ctl(0, 0, 0, 4'($urandom));
            c = 5'($urandom);
            if (($urandom % 2) == 0) begin
                logic [15:0] d;
                d = 16'($urandom);
                bus_wr({1'b1, c}, d);
                model[widx(cur_stream, c)] = d;
                valid[widx(cur_stream, c)] = 1;
            end else if (valid[widx(cur_stream, c)]) begin
                bus_rd({1'b1, c}, rd);
                check("R3 random read", rd, model[widx(cur_stream, c)]);
            end
        end

        // R4 mem_sel=1 reads data memory, writes reach connection memory
        set_ctl(0, 0, 1, 4'h3);
        bus_rd(6'h27, rd); check("R4 dm read", rd, 16'hD000 | 16'(widx(4'h3, 5'd7)));
        check("R4 dm addr", {7'b0, dm_rd_addr}, 16'(widx(4'h3, 5'd7)));
        bus_wr(6'h27, 16'h1234); model[widx(4'h3, 5'd7)] = 16'h1234; valid[widx(4'h3, 5'd7)] = 1;
        bus_rd(6'h27, rd); check("R4 dm read after write", rd, 16'hD000 | 16'(widx(4'h3, 5'd7)));
        set_ctl(0, 0, 0, 4'h3);
        bus_rd(6'h27, rd); check("R4 write landed in cm", rd, 16'h1234);

        // R6 trigger without arm has no effect; R10 pattern stored
        bus_wr(6'h01, fill_val(1, 5'h15));
        bus_rd(6'h01, rd); check("R6 go stays 0 / R10 pattern", rd, fill_val(0, 5'h15));
        pulse_frame(); idle(20); pulse_frame(); idle(20); pulse_frame(); idle(5);
        bus_rd(6'h27, rd); check("R6 memory unchanged", rd, 16'h1234);

        // R8 R9 R10 armed fill
        set_ctl(1, 0, 0, 4'h3);
        bus_wr(6'h01, fill_val(1, 5'h0B));
        bus_rd(6'h01, rd); check("R10 single write", rd, fill_val(1, 5'h0B));
        idle(30);
        bus_rd(6'h01, rd); check("R8 busy before frame", rd, fill_val(1, 5'h0B));
        pulse_frame();
        idle(600);
        bus_rd(6'h01, rd); check("R8 busy after pulse1", rd, fill_val(1, 5'h0B));
        bus_wr(6'h01, fill_val(0, 5'h1F));
        pulse_frame();
        idle(50);
        bus_wr(6'h27, 16'hBEEF);
        bus_rd(6'h01, rd); check("R9 fill write ignored", rd, fill_val(1, 5'h0B));
        bus_rd(6'h01, rd); check("R8 busy after pulse2", rd, fill_val(1, 5'h0B));
        pulse_frame();
        bus_rd(6'h01, rd); check("R8 go cleared", rd, fill_val(0, 5'h0B));
        bus_rd(6'h27, rd); check("R9 word write dropped", rd, 16'h5800);

        // R7 every word holds the pattern
        for (int s = 0; s < 16; s++) begin
            set_ctl(1, 0, 0, 4'(s));
            for (int c = 0; c < 32; c++) begin
                bus_rd({1'b1, 5'(c)}, rd);
                check("R7 fill word", rd, 16'h5800);
            end
        end

        // R9 writes resume; R7 second pattern
        bus_wr(6'h22, 16'h0F0F);
        bus_rd(6'h22, rd); check("R9 write resumes", rd, 16'h0F0F);
        bus_wr(6'h01, fill_val(1, 5'h1F));
        pulse_frame(); idle(560); pulse_frame(); idle(10); pulse_frame();
        bus_rd(6'h01, rd); check("R8 second fill done", rd, fill_val(0, 5'h1F));
        bus_rd(6'h22, rd); check("R7 second pattern", rd, 16'hF800);
        set_ctl(1, 0, 0, 4'h0);
        bus_rd(6'h20, rd); check("R7 second pattern word0", rd, 16'hF800);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule